// File: doc/BRIEF.md
# TDC Timestamp Merging Unit

This block turns a raw reading from a time-to-digital converter into a calibrated timestamp. Each input beat carries a seconds value, a packed cycle word (coarse reference count plus a small start-offset phase), the converter's 17-bit fine tag and a signed sub-cycle offset. The fine tag has a start-offset constant removed. When that adjusted fine value shows that the fine measurement wrapped past the coarse sample, the coarse count is pulled back by one. The coarse count is then scaled by 32, and the fine value is multiplied by a calibration scale factor. The integer part of the product goes into the coarse result and a 12-bit fraction is split off.

Input and output are valid/ready streams. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high, and delivered on an edge where `out_valid` and `out_ready` are both high. The three configuration inputs are plain levels. They are sampled only on the accepting edge of each beat. The pipeline is three registers deep and advances as a whole whenever its last stage is empty or being drained. So `in_ready` drops only while a held output is stalled by a low `out_ready`.

Top module: `tdc_ts_merge`

## Requirements
- R1: `in_cycles` is split into a coarse count in bits 27..5 and a start-offset phase in bits 4..0.
- R2: The adjusted fine value is the signed difference `in_fine - cfg_start`, and it may be negative.
- R3: The coarse count is reduced by one, modulo 2^23, when the phase is less than or equal to `cfg_wrap[7:0]` and the adjusted fine value is strictly greater than `cfg_wrap[30:8]`. Otherwise the count is left as it is.
- R4: `out_coarse` is the 32-bit wrapped sum of three terms: the corrected coarse count times 32, the sign-extended 6-bit `in_subcyc`, and the product of the adjusted fine value and `cfg_scale` shifted right arithmetically by 24.
- R5: `out_frac` is bits 23..12 of that signed product.
- R6: `out_sec` equals the `in_sec` of the same beat, unchanged.
- R7: With `out_ready` high, a beat accepted on edge N appears on the outputs right after edge N+2, and beats can be accepted back to back. `in_ready` is high whenever `out_valid` is low.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs hold their values. No beat is lost or duplicated.
- R9: Every beat uses the configuration present on its accepting edge. Later changes do not alter beats already in flight.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat may be accepted |
| in_sec | input | 40 | Seconds value |
| in_cycles | input | 28 | Coarse count (27..5) and phase (4..0) |
| in_fine | input | 17 | Raw converter fine tag |
| in_subcyc | input | 6 | Two's-complement sub-cycle offset |
| cfg_wrap | input | 31 | Fine threshold (30..8), coarse threshold (7..0) |
| cfg_scale | input | 32 | Unsigned fine scale factor |
| cfg_start | input | 17 | Start-offset constant removed from the fine tag |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_sec | output | 40 | Seconds of the timestamp |
| out_coarse | output | 32 | Coarse part in 1/32 cycle units |
| out_frac | output | 12 | Fractional part |

## Verification
When `out_ready` stays high, each beat's seconds, coarse and fraction are due together: they show just after the second edge following the accepting edge. The bench therefore notes the cycle in which it sees each acceptance and requires the matching output exactly three cycles later. Under back-pressure, timing is not fixed. There the bench compares only order and content against a queue of predictions made at acceptance time, and in every stalled cycle it checks that the outputs held still and `in_ready` stayed low. All observations are taken at the falling edge, half a cycle clear of the register updates.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int unsigned SEC_W_D    = 40;
  localparam int unsigned COARSE_W_D = 23;
  localparam int unsigned PHASE_W_D  = 5;
  localparam int unsigned FINE_W_D   = 17;
  localparam int unsigned SUB_W_D    = 6;
  localparam int unsigned SCALE_W_D  = 32;
  localparam int unsigned FRAC_W_D   = 12;
  localparam int unsigned OUT_W_D    = 32;
  localparam int unsigned CTHR_W_D   = 8;
  localparam int unsigned FTHR_W_D   = 23;
  localparam int unsigned SHIFT_D    = 24;
endpackage

// File: rtl/tsm_adjust.sv
module tsm_adjust #(
  parameter int unsigned SEC_W    = 40,
  parameter int unsigned COARSE_W = 23,
  parameter int unsigned PHASE_W  = 5,
  parameter int unsigned FINE_W   = 17,
  parameter int unsigned SUB_W    = 6,
  parameter int unsigned SCALE_W  = 32,
  parameter int unsigned CTHR_W   = 8,
  parameter int unsigned FTHR_W   = 23,
  localparam int unsigned CYC_W   = COARSE_W + PHASE_W,
  localparam int unsigned CFG_W   = CTHR_W + FTHR_W,
  localparam int unsigned ADJ_W   = FINE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    i_valid,
  input  logic [SEC_W-1:0]        i_sec,
  input  logic [CYC_W-1:0]        i_cycles,
  input  logic [FINE_W-1:0]       i_fine,
  input  logic [SUB_W-1:0]        i_sub,
  input  logic [CFG_W-1:0]        i_wrap,
  input  logic [SCALE_W-1:0]      i_scale,
  input  logic [FINE_W-1:0]       i_start,
  output logic                    o_valid,
  output logic [SEC_W-1:0]        o_sec,
  output logic [COARSE_W-1:0]     o_coarse,
  output logic signed [ADJ_W-1:0] o_adj,
  output logic [SUB_W-1:0]        o_sub,
  output logic [SCALE_W-1:0]      o_scale
);
  localparam int unsigned PCMP_W = CTHR_W + PHASE_W;
  localparam int unsigned FCMP_W = ((ADJ_W > FTHR_W) ? ADJ_W : FTHR_W) + 1;

  logic [COARSE_W-1:0]     coarse_raw;
  logic [PHASE_W-1:0]      phase;
  logic [CTHR_W-1:0]       c_thr;
  logic [FTHR_W-1:0]       f_thr;
  logic signed [ADJ_W-1:0] adj_c;
  logic signed [FCMP_W-1:0] adj_x, thr_x;
  logic                    phase_low, fine_high, wrapped;

  assign coarse_raw = i_cycles[CYC_W-1:PHASE_W];
  assign phase      = i_cycles[PHASE_W-1:0];
  assign c_thr      = i_wrap[CTHR_W-1:0];
  assign f_thr      = i_wrap[CFG_W-1:CTHR_W];

  assign adj_c     = $signed({1'b0, i_fine}) - $signed({1'b0, i_start});
  assign adj_x     = FCMP_W'(adj_c);
  assign thr_x     = FCMP_W'({1'b0, f_thr});
  assign phase_low = PCMP_W'(phase) <= PCMP_W'(c_thr);
  assign fine_high = adj_x > thr_x;
  assign wrapped   = phase_low && fine_high;

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else if (en) o_valid <= i_valid;
  end

  always_ff @(posedge clk) begin
    if (en && i_valid) begin
      o_sec    <= i_sec;
      o_coarse <= coarse_raw - COARSE_W'(wrapped);
      o_adj    <= adj_c;
      o_sub    <= i_sub;
      o_scale  <= i_scale;
    end
  end
endmodule

// File: rtl/tsm_scale.sv
module tsm_scale #(
  parameter int unsigned SEC_W    = 40,
  parameter int unsigned COARSE_W = 23,
  parameter int unsigned PHASE_W  = 5,
  parameter int unsigned FINE_W   = 17,
  parameter int unsigned SUB_W    = 6,
  parameter int unsigned SCALE_W  = 32,
  parameter int unsigned OUT_W    = 32,
  localparam int unsigned ADJ_W   = FINE_W + 1,
  localparam int unsigned PROD_W  = ADJ_W + SCALE_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     i_valid,
  input  logic [SEC_W-1:0]         i_sec,
  input  logic [COARSE_W-1:0]      i_coarse,
  input  logic signed [ADJ_W-1:0]  i_adj,
  input  logic [SUB_W-1:0]         i_sub,
  input  logic [SCALE_W-1:0]       i_scale,
  output logic                     o_valid,
  output logic [SEC_W-1:0]         o_sec,
  output logic [OUT_W-1:0]         o_cext,
  output logic signed [PROD_W-1:0] o_prod,
  output logic [SUB_W-1:0]         o_sub
);
  logic signed [PROD_W-1:0] prod_c;
  logic [OUT_W-1:0]         cext_c;

  assign prod_c = PROD_W'(i_adj) * PROD_W'($signed({1'b0, i_scale}));
  assign cext_c = OUT_W'({i_coarse, {PHASE_W{1'b0}}});

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else if (en) o_valid <= i_valid;
  end

  always_ff @(posedge clk) begin
    if (en && i_valid) begin
      o_sec  <= i_sec;
      o_cext <= cext_c;
      o_prod <= prod_c;
      o_sub  <= i_sub;
    end
  end
endmodule

// File: rtl/tsm_pack.sv
module tsm_pack #(
  parameter int unsigned SEC_W   = 40,
  parameter int unsigned SUB_W   = 6,
  parameter int unsigned PROD_W  = 51,
  parameter int unsigned OUT_W   = 32,
  parameter int unsigned FRAC_W  = 12,
  parameter int unsigned SHIFT   = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     i_valid,
  input  logic [SEC_W-1:0]         i_sec,
  input  logic [OUT_W-1:0]         i_cext,
  input  logic signed [PROD_W-1:0] i_prod,
  input  logic [SUB_W-1:0]         i_sub,
  output logic                     o_valid,
  output logic [SEC_W-1:0]         o_sec,
  output logic [OUT_W-1:0]         o_coarse,
  output logic [FRAC_W-1:0]        o_frac
);
  logic [OUT_W-1:0]  sub_x, whole;
  logic [OUT_W-1:0]  sum_c;
  logic [FRAC_W-1:0] frac_c;

  assign sub_x  = {{(OUT_W-SUB_W){i_sub[SUB_W-1]}}, i_sub};
  assign whole  = OUT_W'(i_prod >>> SHIFT);
  assign sum_c  = i_cext + sub_x + whole;
  assign frac_c = i_prod[SHIFT-1 -: FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else if (en) o_valid <= i_valid;
  end

  always_ff @(posedge clk) begin
    if (en && i_valid) begin
      o_sec    <= i_sec;
      o_coarse <= sum_c;
      o_frac   <= frac_c;
    end
  end
endmodule

// File: rtl/tdc_ts_merge.sv
module tdc_ts_merge
  import tsm_pkg::*;
#(
  parameter int unsigned SEC_W    = SEC_W_D,
  parameter int unsigned COARSE_W = COARSE_W_D,
  parameter int unsigned PHASE_W  = PHASE_W_D,
  parameter int unsigned FINE_W   = FINE_W_D,
  parameter int unsigned SUB_W    = SUB_W_D,
  parameter int unsigned SCALE_W  = SCALE_W_D,
  parameter int unsigned FRAC_W   = FRAC_W_D,
  parameter int unsigned OUT_W    = OUT_W_D,
  parameter int unsigned CTHR_W   = CTHR_W_D,
  parameter int unsigned FTHR_W   = FTHR_W_D,
  parameter int unsigned SHIFT    = SHIFT_D,
  localparam int unsigned CYC_W   = COARSE_W + PHASE_W,
  localparam int unsigned CFG_W   = CTHR_W + FTHR_W,
  localparam int unsigned ADJ_W   = FINE_W + 1,
  localparam int unsigned PROD_W  = ADJ_W + SCALE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEC_W-1:0]  in_sec,
  input  logic [CYC_W-1:0]  in_cycles,
  input  logic [FINE_W-1:0] in_fine,
  input  logic [SUB_W-1:0]  in_subcyc,
  input  logic [CFG_W-1:0]  cfg_wrap,
  input  logic [SCALE_W-1:0] cfg_scale,
  input  logic [FINE_W-1:0] cfg_start,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SEC_W-1:0]  out_sec,
  output logic [OUT_W-1:0]  out_coarse,
  output logic [FRAC_W-1:0] out_frac
);
  logic advance;

  logic                     s1_valid;
  logic [SEC_W-1:0]         s1_sec;
  logic [COARSE_W-1:0]      s1_coarse;
  logic signed [ADJ_W-1:0]  s1_adj;
  logic [SUB_W-1:0]         s1_sub;
  logic [SCALE_W-1:0]       s1_scale;

  logic                     s2_valid;
  logic [SEC_W-1:0]         s2_sec;
  logic [OUT_W-1:0]         s2_cext;
  logic signed [PROD_W-1:0] s2_prod;
  logic [SUB_W-1:0]         s2_sub;

  // whole pipe moves unless the last stage holds a beat nobody takes
  assign advance  = out_ready || !out_valid;
  assign in_ready = advance;

  tsm_adjust #(
    .SEC_W(SEC_W), .COARSE_W(COARSE_W), .PHASE_W(PHASE_W), .FINE_W(FINE_W),
    .SUB_W(SUB_W), .SCALE_W(SCALE_W), .CTHR_W(CTHR_W), .FTHR_W(FTHR_W)
  ) u_adjust (
    .clk(clk), .rst(rst), .en(advance), .i_valid(in_valid),
    .i_sec(in_sec), .i_cycles(in_cycles), .i_fine(in_fine), .i_sub(in_subcyc),
    .i_wrap(cfg_wrap), .i_scale(cfg_scale), .i_start(cfg_start),
    .o_valid(s1_valid), .o_sec(s1_sec), .o_coarse(s1_coarse), .o_adj(s1_adj),
    .o_sub(s1_sub), .o_scale(s1_scale)
  );

  tsm_scale #(
    .SEC_W(SEC_W), .COARSE_W(COARSE_W), .PHASE_W(PHASE_W), .FINE_W(FINE_W),
    .SUB_W(SUB_W), .SCALE_W(SCALE_W), .OUT_W(OUT_W)
  ) u_scale (
    .clk(clk), .rst(rst), .en(advance), .i_valid(s1_valid),
    .i_sec(s1_sec), .i_coarse(s1_coarse), .i_adj(s1_adj), .i_sub(s1_sub),
    .i_scale(s1_scale),
    .o_valid(s2_valid), .o_sec(s2_sec), .o_cext(s2_cext), .o_prod(s2_prod),
    .o_sub(s2_sub)
  );

  tsm_pack #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .PROD_W(PROD_W), .OUT_W(OUT_W),
    .FRAC_W(FRAC_W), .SHIFT(SHIFT)
  ) u_pack (
    .clk(clk), .rst(rst), .en(advance), .i_valid(s2_valid),
    .i_sec(s2_sec), .i_cext(s2_cext), .i_prod(s2_prod), .i_sub(s2_sub),
    .o_valid(out_valid), .o_sec(out_sec), .o_coarse(out_coarse), .o_frac(out_frac)
  );
endmodule

// File: rtl/tdc_ts_merge_chk.sv
module tdc_ts_merge_chk #(
  parameter int unsigned SEC_W  = 40,
  parameter int unsigned OUT_W  = 32,
  parameter int unsigned FRAC_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SEC_W-1:0]  out_sec,
  input logic [OUT_W-1:0]  out_coarse,
  input logic [FRAC_W-1:0] out_frac
);
  assert_reset_empty_R10: assert property (@(posedge clk) rst |=> !out_valid);

  assert_ready_when_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_three_edge_latency_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_ready, 3) && $past(out_ready, 1) && $past(out_ready, 2)
     && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)) |-> out_valid);

  assert_stall_blocks_input_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_output_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_sec) && $stable(out_coarse) && $stable(out_frac)));
endmodule

bind tdc_ts_merge tdc_ts_merge_chk #(
  .SEC_W(SEC_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)
) u_tdc_ts_merge_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sec(out_sec),
  .out_coarse(out_coarse), .out_frac(out_frac)
);

// File: tb/test_tdc_ts_merge.sv
`timescale 1ns/1ps
module test_tdc_ts_merge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [39:0] in_sec = '0;
  logic [27:0] in_cycles = '0;
  logic [16:0] in_fine = '0;
  logic [5:0]  in_subcyc = '0;
  logic [30:0] cfg_wrap;
  logic [31:0] cfg_scale;
  logic [16:0] cfg_start;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [39:0] out_sec;
  logic [31:0] out_coarse;
  logic [11:0] out_frac;

  always #4 clk = ~clk;

  tdc_ts_merge i_tdc_ts_merge (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sec(in_sec), .in_cycles(in_cycles), .in_fine(in_fine),
    .in_subcyc(in_subcyc), .cfg_wrap(cfg_wrap), .cfg_scale(cfg_scale),
    .cfg_start(cfg_start), .out_valid(out_valid), .out_ready(out_ready),
    .out_sec(out_sec), .out_coarse(out_coarse), .out_frac(out_frac)
  );

  typedef struct {
    logic [39:0] sec;
    logic [31:0] coarse;
    logic [11:0] frac;
    longint      acc;
    bit          timed;
    int          tag;
  } exp_t;

  exp_t   q[$];
  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  bit     timed_mode = 1'b1;
  int     cur_tag = 1;
  bit     done = 1'b0;
  bit          held = 1'b0;
  logic [39:0] h_sec;
  logic [31:0] h_coarse;
  logic [11:0] h_frac;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural model of the requirements
  function automatic exp_t model(input logic [39:0] s, input logic [27:0] cw,
                                 input logic [16:0] f, input logic [5:0] sb,
                                 input logic [30:0] w, input logic [31:0] sc,
                                 input logic [16:0] st);
    exp_t   e;
    longint coarse, phase, adj, cth, fth, prod, sbx, tot;
    coarse = longint'(cw >> 5);           // R1
    phase  = longint'(cw & 28'h1f);
    adj    = longint'(f) - longint'(st);  // R2
    cth    = longint'(w & 31'hff);
    fth    = longint'(w >> 8);
    if (phase <= cth && adj > fth) coarse = (coarse - 1) & 64'h7fffff; // R3
    sbx    = longint'(sb);
    if (sbx >= 32) sbx = sbx - 64;
    prod   = adj * longint'(sc);
    tot    = coarse * 32 + sbx + (prod >>> 24);                        // R4
    e.sec    = s;                                                      // R6
    e.coarse = tot[31:0];
    e.frac   = prod[23:12];                                            // R5
    e.acc    = 0;
    e.timed  = 1'b0;
    e.tag    = 0;
    return e;
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (held) begin  // R8 held output
        check(out_valid && out_sec == h_sec && out_coarse == h_coarse && out_frac == h_frac,
              "R8", "stalled output changed", longint'(out_coarse), longint'(h_coarse));
      end
      if (out_valid && !out_ready)
        check(!in_ready, "R8", "in_ready during stall", longint'(in_ready), 0);
      if (in_valid && in_ready) begin
        exp_t e;
        e = model(in_sec, in_cycles, in_fine, in_subcyc, cfg_wrap, cfg_scale, cfg_start);
        e.acc   = cyc;
        e.timed = timed_mode;
        e.tag   = cur_tag;
        q.push_back(e);
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected output beat", 1, 0);
        end else begin
          exp_t e;
          string rq;
          e  = q.pop_front();
          rq = $sformatf("R%0d", e.tag);
          check(out_sec == e.sec, rq, "seconds", longint'(out_sec), longint'(e.sec));
          check(out_coarse == e.coarse, rq, "coarse", longint'(out_coarse), longint'(e.coarse));
          check(out_frac == e.frac, rq, "fraction", longint'(out_frac), longint'(e.frac));
          if (e.timed)  // R7 latency
            check(cyc == e.acc + 3, "R7", "output cycle", cyc, e.acc + 3);
        end
      end
      held = out_valid && !out_ready;
      h_sec = out_sec; h_coarse = out_coarse; h_frac = out_frac;
    end
  end

  task automatic send(input logic [39:0] s, input logic [22:0] coarse,
                      input logic [4:0] ph, input logic [16:0] f,
                      input logic [5:0] sb, input int tag);
    in_sec = s; in_cycles = {coarse, ph}; in_fine = f; in_subcyc = sb;
    cur_tag = tag;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (400) begin
      @(negedge clk);
      if (q.size() == 0) break;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_wrap  = 31'(26 | (1500 << 8));
    cfg_scale = 32'd84977;
    cfg_start = 17'd17000;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!out_valid, "R10", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready, "R10", "in_ready after reset", longint'(in_ready), 1);
    @(posedge clk); #1;

    send(40'd5, 23'd1000, 5'd31, 17'd20000, 6'd0, 1);     // R1 phase above threshold
    send(40'd6, 23'd1000, 5'd26, 17'd18501, 6'd0, 3);     // R3 phase equal, fine above
    send(40'd7, 23'd1000, 5'd26, 17'd18500, 6'd0, 3);     // R3 fine equal: no correction
    send(40'd8, 23'd1000, 5'd27, 17'd18501, 6'd0, 3);     // R3 phase above: no correction
    send(40'd9, 23'd0, 5'd0, 17'd30000, 6'd0, 3);         // R3 coarse wraps below zero
    send(40'd10, 23'd500, 5'd0, 17'd100, 6'd0, 2);        // R2 negative adjusted fine
    send(40'd11, 23'd700, 5'd31, 17'd17000, 6'h20, 4);    // R4 sub offset -32
    send(40'd12, 23'd700, 5'd31, 17'd17000, 6'h1f, 4);    // R4 sub offset +31
    send(40'hff_ffff_ffff, 23'h7fffff, 5'd31, 17'h1ffff, 6'd0, 6); // R6 extremes
    drain();
    cfg_scale = 32'h0100_0000;                            // R4 integer only
    send(40'd13, 23'd3, 5'd31, 17'd17123, 6'd0, 4);
    drain();
    cfg_scale = 32'h0000_1000;                            // R5 fraction only
    send(40'd14, 23'd3, 5'd31, 17'd19000, 6'd0, 5);
    send(40'd15, 23'd3, 5'd31, 17'd16000, 6'd0, 5);
    drain();
    cfg_scale = 32'd84977;

    // R7 back-to-back beats, timed
    in_valid = 1'b1;
    cur_tag = 7;
    for (int i = 0; i < 24; i++) begin
      in_sec = 40'(i + 100); in_cycles = 28'($urandom); in_fine = 17'($urandom);
      in_subcyc = 6'($urandom);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    drain();

    // R9 and R8: random back-pressure, configuration changes after each acceptance
    timed_mode = 1'b0;
    fork
      begin
        for (int i = 0; i < 160; i++) begin
          repeat ($urandom % 3) begin @(posedge clk); #1; end
          send(40'($urandom), 23'($urandom), 5'($urandom % 32), 17'($urandom),
               6'($urandom), 9);
          cfg_wrap  = {23'($urandom % 4000), 8'($urandom % 32)};
          cfg_scale = $urandom;
          cfg_start = 17'($urandom);
        end
      end
      begin
        for (int i = 0; i < 1200; i++) begin
          @(posedge clk); #1;
          out_ready = ($urandom % 3) != 0;
        end
        out_ready = 1'b1;
      end
    join
    out_ready = 1'b1;
    drain();
    check(q.size() == 0, "R8", "beats left undelivered", longint'(q.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule